// File: doc/BRIEF.md
# Return Address Stack

This block predicts where a return instruction will jump. Each time the fetch logic sees a call, it raises a call strobe and gives the call's own address. The block works out the address of the next sequential instruction and keeps it in a small last-in first-out store. When the fetch logic sees a return, the stored address at the top is already shown as the predicted target. The return strobe then removes that entry, so the entry below it predicts the next return.

The store has a fixed number of slots and the top pointer wraps around them. Calls nested deeper than the capacity overwrite the oldest slot and never stall. The most recent returns therefore still predict correctly, and only the outermost returns lose their entries. A valid flag is low whenever nothing is stored, so a fallback predictor can be used in that case. A call and a return in the same cycle replace the top entry and leave the pointer where it is.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the valid output is low, and it stays low until a call strobe is accepted.
- R2: A call alone stores the call address plus INST_BYTES (4 by default). From the next cycle the valid output is high and the predicted target equals that sum.
- R3: Entries come back in last-in first-out order: each return alone exposes the entry pushed before the one it removes.
- R4: The occupancy never exceeds DEPTH (8 by default). After any run of calls, at most DEPTH returns in a row find the valid output high.
- R5: Once DEPTH entries are held, a further call overwrites the oldest entry. After DEPTH+2 calls, the DEPTH returns that follow see the last DEPTH return addresses, newest first.
- R6: A return while the valid output is low has no effect: valid stays low, and a following call and return behave as on a fresh stack.
- R7: A call and a return in the same cycle with a non-empty stack replace the top entry with the new return address. The occupancy does not change, and the entry below it is still intact.
- R8: A call and a return in the same cycle on an empty stack leave exactly one entry, holding the new return address.
- R9: The return address is formed modulo 2^ADDR_W, so a call at the highest word address yields target 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | A call was fetched this cycle; push its return address |
| call_pc_i | input | ADDR_W | Address of the call instruction |
| ret_i | input | 1 | A return was fetched this cycle; remove the top entry |
| pred_tgt_o | output | ADDR_W | Predicted return target (top entry) |
| pred_vld_o | output | 1 | High when at least one entry is held |

## Verification
The properties assume that the call and return strobes are sampled as clean single-cycle events on the rising edge, and that the call address is stable whenever the call strobe is high. They take no view of whether the call and return pattern makes sense as a program. The stimulus changes inputs only at the falling edge and holds each pattern for one full cycle. It deliberately includes nonsensical patterns, such as returns on an empty stack, pairs in the same cycle and more calls than the capacity, so that the wrap and saturation paths are exercised.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } ras_op_e;

  function automatic ras_op_e decode_op(input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return OP_PUSH;
      2'b01:   return OP_POP;
      2'b11:   return OP_SWAP;
      default: return OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ras_op_e          op,
  output logic [PTR_W-1:0] tos_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] wrap_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] tos_q, tos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_empty;

  assign is_empty = (cnt_q == '0);

  always_comb begin
    tos_d    = tos_q;
    cnt_d    = cnt_q;
    wr_en_o  = 1'b0;
    wr_idx_o = tos_q;
    case (op)
      OP_PUSH: begin
        tos_d    = wrap_inc(tos_q);
        wr_idx_o = wrap_inc(tos_q);
        wr_en_o  = 1'b1;
        cnt_d    = (cnt_q == FULL_CNT) ? FULL_CNT : cnt_q + 1'b1;
      end
      OP_POP: begin
        if (!is_empty) begin
          tos_d = wrap_dec(tos_q);
          cnt_d = cnt_q - 1'b1;
        end
      end
      OP_SWAP: begin
        wr_en_o = 1'b1;
        if (is_empty) cnt_d = CNT_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
      cnt_q <= '0;
    end else begin
      tos_q <= tos_d;
      cnt_q <= cnt_d;
    end
  end

  assign tos_o   = tos_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);

  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(g))) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DEPTH      = 8,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_pc_i,
  input  logic              ret_i,
  output logic [ADDR_W-1:0] pred_tgt_o,
  output logic              pred_vld_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [ADDR_W-1:0] next_seq(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(INST_BYTES);
  endfunction

  ras_op_e           op;
  logic [PTR_W-1:0]  tos, wr_idx;
  logic              wr_en;
  logic [CNT_W-1:0]  occ_cnt;
  logic [ADDR_W-1:0] ret_addr;
  logic              push_evt, pop_evt, swap_evt;

  assign op       = decode_op(call_i, ret_i);
  assign push_evt = (op == OP_PUSH);
  assign pop_evt  = (op == OP_POP);
  assign swap_evt = (op == OP_SWAP);
  assign ret_addr = next_seq(call_pc_i);

  ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .tos_o    (tos),
    .wr_idx_o (wr_idx),
    .wr_en_o  (wr_en),
    .count_o  (occ_cnt)
  );

  ras_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (ret_addr),
    .rd_idx  (tos),
    .rd_data (pred_tgt_o)
  );

  assign pred_vld_o = (occ_cnt != '0);

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int ADDR_W     = 32,
  parameter int DEPTH      = 8,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_evt,
  input logic              pop_evt,
  input logic              swap_evt,
  input logic [ADDR_W-1:0] call_pc,
  input logic [ADDR_W-1:0] tgt,
  input logic              vld,
  input logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  p_push_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (vld && tgt == $past(call_pc) + STEP));

  p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && count != '0) |=> (count == $past(count) - 1'b1));

  p_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && count < FULL) |=> (count == $past(count) + 1'b1));

  p_full_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && count == FULL) |=> (count == FULL));

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !vld) |=> !vld);

  p_swap_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && vld) |=> (count == $past(count) && tgt == $past(call_pc) + STEP));

  p_swap_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && !vld) |=> (count == CNT_W'(1) && tgt == $past(call_pc) + STEP));

  p_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_evt, pop_evt, swap_evt}));

endmodule

bind ret_addr_stack ras_checker #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .INST_BYTES(INST_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push_evt (push_evt),
  .pop_evt  (pop_evt),
  .swap_evt (swap_evt),
  .call_pc  (call_pc_i),
  .tgt      (pred_tgt_o),
  .vld      (pred_vld_o),
  .count    (occ_cnt)
);

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DEPTH = 8;
  localparam int NVEC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_i = 1'b0;
  logic          ret_i = 1'b0;
  logic [AW-1:0] call_pc_i = '0;
  logic [AW-1:0] pred_tgt_o;
  logic          pred_vld_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW), .DEPTH(DEPTH), .INST_BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
    .ret_i(ret_i), .pred_tgt_o(pred_tgt_o), .pred_vld_o(pred_vld_o)
  );

  // {req[3:0], call, ret, pc[31:0], exp_vld, exp_tgt[31:0]}
  localparam logic [70:0] VEC [NVEC] = '{
    {4'd2, 1'b1, 1'b0, 32'h0000_1000, 1'b1, 32'h0000_1004}, // R2
    {4'd2, 1'b1, 1'b0, 32'h0000_2000, 1'b1, 32'h0000_2004}, // R2
    {4'd2, 1'b1, 1'b0, 32'h0000_3000, 1'b1, 32'h0000_3004}, // R2
    {4'd3, 1'b0, 1'b1, 32'h0,         1'b1, 32'h0000_2004}, // R3
    {4'd7, 1'b1, 1'b1, 32'h0000_5000, 1'b1, 32'h0000_5004}, // R7 swap
    {4'd7, 1'b0, 1'b1, 32'h0,         1'b1, 32'h0000_1004}, // R7 entry below kept
    {4'd3, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0},         // R3 now empty
    {4'd6, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0},         // R6 pop on empty
    {4'd9, 1'b1, 1'b0, 32'hFFFF_FFFC, 1'b1, 32'h0000_0000}, // R9 wrap
    {4'd6, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0},         // R6 fresh after empty pop
    {4'd8, 1'b1, 1'b1, 32'h0000_7000, 1'b1, 32'h0000_7004}, // R8 swap on empty
    {4'd8, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0}          // R8 exactly one entry
  };

  task automatic check(input string req, input logic exp_vld, input logic [AW-1:0] exp_tgt);
    n_checks++;
    if (pred_vld_o !== exp_vld || (exp_vld && pred_tgt_o !== exp_tgt)) begin
      n_errors++;
      $display("FAIL %s: vld=%0b tgt=%h expected vld=%0b tgt=%h",
               req, pred_vld_o, pred_tgt_o, exp_vld, exp_tgt);
    end
  endtask

  // drive at falling edge, let one rising edge pass, sample at next falling edge
  task automatic step(input logic c, input logic r, input logic [AW-1:0] pc);
    call_i = c; ret_i = r; call_pc_i = pc;
    @(negedge clk);
    call_i = 0; ret_i = 0; call_pc_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1", 1'b0, '0);

    for (int i = 0; i < NVEC; i++) begin
      logic [70:0] v;
      v = VEC[i];
      step(v[66], v[65], v[64:33]);
      check($sformatf("R%0d vec%0d", v[70:67], i), v[32], v[31:0]);
    end

    // R5 / R4: overflow by two, then drain
    do_reset();
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, AW'(32'h100 * (i + 1)));
    check("R5 top after overflow", 1'b1, AW'(32'h100 * (DEPTH + 2) + 4));
    for (int i = DEPTH + 1; i >= 3; i--) begin
      step(1'b0, 1'b1, '0);
      check("R5 drain order", 1'b1, AW'(32'h100 * i + 4));
    end
    step(1'b0, 1'b1, '0);
    check("R4 empty after DEPTH returns", 1'b0, '0);

    // R1: reset mid-run clears the stack
    step(1'b1, 1'b0, 32'h0000_4440);
    check("R2 before reset", 1'b1, 32'h0000_4444);
    do_reset();
    check("R1 reset clears", 1'b0, '0);
    step(1'b0, 1'b1, '0);
    check("R6 pop after reset", 1'b0, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule